// File: doc/BRIEF.md
# Condition-Code Masked Destination Merger

This block is the write-back stage of a four-lane floating-point vector execution unit. Each issued instruction brings a result vector, the old contents of its destination register, a static per-lane write mask, and a condition test. The condition test names one of two condition registers, a per-lane swizzle that chooses which code each lane tests, and a rule. A lane of the destination takes the new value only when its mask bit is set and its swizzled condition code passes the rule. Every other lane keeps its old value. The merged vector comes out one clock after the issue.

Each of the two condition registers holds four 2-bit codes: greater, equal, less, or unordered. An instruction can ask for the codes of the lanes it writes to be regenerated from the written values, in one chosen register. It can also clamp floating-point results to [0,1] before the merge. Integer results from address arithmetic use the same path with clamping skipped. A run-start pulse sets both condition registers back to all-equal at the start of each program.

Top module: `ccm_merge_unit`

## Requirements
- R1: After reset, and on the cycle after `run_start` is high, both condition registers read all-equal (8'h55) and `dst_valid` is 0. `run_start` takes priority over a same-cycle `issue`: that instruction is dropped and `dst_out` holds.
- R2: Condition codes are 2 bits, with lane i at bits [2i+1:2i] of `cc0_out`/`cc1_out`: greater=2'b00, equal=2'b01, less=2'b10, unordered=2'b11. Data lane i sits at bits [32i+31:32i].
- R3: A float code is unordered for NaN (exponent all ones, mantissa nonzero) and equal for +0.0 or -0.0. Otherwise it is less when the sign is set and greater when the sign is clear, with +infinity giving greater.
- R4: `test_rule` encoding: 0 always, 1 never, 2 equal, 3 not-equal, 4 less, 5 greater-or-equal (greater or equal), 6 less-or-equal (less or equal), 7 greater. An unordered code passes only not-equal and always.
- R5: Lane i tests code number `test_swz[2i+1:2i]` of the register picked by `test_cc_sel` (0 or 1).
- R6: `dst_out` lane i takes the new value if and only if `wr_mask[i]` is set and the lane's test passes; otherwise it takes the `dst_vec` lane. The result appears with `dst_valid`=1 one clock after `issue`. With no issue, `dst_valid` is 0 and `dst_out` holds.
- R7: With `cc_wr_en`=1, only the written lanes of register `cc_wr_sel` take new codes. Its other lanes and the other register keep their codes. With `cc_wr_en`=0 neither register changes.
- R8: With `sat_en`=1 in float mode, written values are clamped to [0,1]. NaN and every negative value, including -0.0, become +0.0. Values above 1.0, including +infinity, become 1.0. Codes come from the clamped value.
- R9: With `int_mode`=1, clamping is skipped even when `sat_en`=1. The code is taken from a signed 32-bit compare with zero and is never unordered.
- R10: The condition test uses the codes held before the current instruction's own update, so an instruction's code update is seen only by the next instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_start | input | 1 | Start of program run; sets both condition registers to all-equal |
| issue | input | 1 | Instruction present this cycle |
| res_vec | input | 128 | Result vector, four 32-bit lanes |
| dst_vec | input | 128 | Old destination contents |
| wr_mask | input | 4 | Static per-lane write mask |
| test_cc_sel | input | 1 | Condition register used for the test |
| test_swz | input | 8 | Per-lane 2-bit code selector for the test |
| test_rule | input | 3 | Test rule code |
| sat_en | input | 1 | Clamp float results to [0,1] |
| int_mode | input | 1 | Result is a signed integer |
| cc_wr_en | input | 1 | Regenerate codes of written lanes |
| cc_wr_sel | input | 1 | Condition register to update |
| dst_out | output | 128 | Merged destination |
| dst_valid | output | 1 | `dst_out` carries a new merge |
| cc0_out | output | 8 | Condition register 0 |
| cc1_out | output | 8 | Condition register 1 |

## Verification
A corrupted condition code shows on `cc0_out` or `cc1_out` on the very next cycle. It also shows on `dst_out` one cycle after the next instruction that tests that lane, so the vectors chain instructions that depend on each other's codes. A wrong lane enable or clamp shows on the affected lane of `dst_out` one clock after issue. Stale or over-eager code updates are caught because every step compares both whole condition registers. The swizzle, unordered handling, signed zero, infinity and integer-mode cases each have their own vectors.

// File: rtl/ccm_pkg.sv
`timescale 1ns/1ps
package ccm_pkg;
  localparam int NUM_CC  = 2;
  localparam int CCSEL_W = $clog2(NUM_CC);

  typedef enum logic [1:0] {
    CC_GT = 2'b00,
    CC_EQ = 2'b01,
    CC_LT = 2'b10,
    CC_UN = 2'b11
  } cc_code_e;

  typedef enum logic [2:0] {
    RULE_TR = 3'd0,
    RULE_FL = 3'd1,
    RULE_EQ = 3'd2,
    RULE_NE = 3'd3,
    RULE_LT = 3'd4,
    RULE_GE = 3'd5,
    RULE_LE = 3'd6,
    RULE_GT = 3'd7
  } cc_rule_e;

  function automatic logic cc_pass(input logic [1:0] code, input logic [2:0] rule);
    logic r;
    case (rule)
      RULE_TR: r = 1'b1;
      RULE_FL: r = 1'b0;
      RULE_EQ: r = (code == CC_EQ);
      RULE_NE: r = (code != CC_EQ);
      RULE_LT: r = (code == CC_LT);
      RULE_GE: r = (code == CC_GT) || (code == CC_EQ);
      RULE_LE: r = (code == CC_LT) || (code == CC_EQ);
      default: r = (code == CC_GT);
    endcase
    return r;
  endfunction
endpackage

// File: rtl/ccm_lane_prep.sv
`timescale 1ns/1ps
module ccm_lane_prep
  import ccm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int EXP_W  = 8
) (
  input  logic [DATA_W-1:0] val_in,
  input  logic              sat_en,
  input  logic              int_mode,
  output logic [DATA_W-1:0] val_out,
  output logic [1:0]        code_out
);
  localparam int MAN_W = DATA_W - 1 - EXP_W;
  localparam logic [DATA_W-1:0] FP_ONE = {2'b00, {(EXP_W-1){1'b1}}, {MAN_W{1'b0}}};

  function automatic logic fp_nan(input logic [DATA_W-1:0] v);
    return (&v[DATA_W-2 -: EXP_W]) && (|v[MAN_W-1:0]);
  endfunction

  logic [DATA_W-1:0] clamped;

  always_comb begin
    clamped = val_in;
    if (sat_en && !int_mode) begin
      if (fp_nan(val_in) || val_in[DATA_W-1])
        clamped = '0;
      else if (val_in > FP_ONE)
        clamped = FP_ONE;
    end
  end

  assign val_out = clamped;

  always_comb begin
    if (int_mode) begin
      if (clamped == '0)             code_out = CC_EQ;
      else if (clamped[DATA_W-1])    code_out = CC_LT;
      else                           code_out = CC_GT;
    end else begin
      if (fp_nan(clamped))           code_out = CC_UN;
      else if (~|clamped[DATA_W-2:0]) code_out = CC_EQ;
      else if (clamped[DATA_W-1])    code_out = CC_LT;
      else                           code_out = CC_GT;
    end
  end
endmodule

// File: rtl/ccm_lane_test.sv
`timescale 1ns/1ps
module ccm_lane_test
  import ccm_pkg::*;
#(
  parameter int LANES = 4,
  parameter int SEL_W = 2
) (
  input  logic [2*LANES-1:0] cc_vec,
  input  logic [SEL_W-1:0]   pick,
  input  logic [2:0]         rule,
  output logic               pass
);
  logic [1:0] code;
  assign code = cc_vec[2*int'(pick) +: 2];
  assign pass = cc_pass(code, rule);
endmodule

// File: rtl/ccm_cc_reg.sv
`timescale 1ns/1ps
module ccm_cc_reg
  import ccm_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               upd,
  input  logic [LANES-1:0]   lane_we,
  input  logic [2*LANES-1:0] new_codes,
  output logic [2*LANES-1:0] cc_q
);
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cc_q <= {LANES{CC_EQ}};
    end else if (upd) begin
      for (int i = 0; i < LANES; i++) begin
        if (lane_we[i]) cc_q[2*i +: 2] <= new_codes[2*i +: 2];
      end
    end
  end
endmodule

// File: rtl/ccm_merge_unit.sv
`timescale 1ns/1ps
module ccm_merge_unit
  import ccm_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int DATA_W = 32,
  parameter int EXP_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    run_start,
  input  logic                    issue,
  input  logic [LANES*DATA_W-1:0] res_vec,
  input  logic [LANES*DATA_W-1:0] dst_vec,
  input  logic [LANES-1:0]        wr_mask,
  input  logic [CCSEL_W-1:0]      test_cc_sel,
  input  logic [LANES*$clog2(LANES)-1:0] test_swz,
  input  logic [2:0]              test_rule,
  input  logic                    sat_en,
  input  logic                    int_mode,
  input  logic                    cc_wr_en,
  input  logic [CCSEL_W-1:0]      cc_wr_sel,
  output logic [LANES*DATA_W-1:0] dst_out,
  output logic                    dst_valid,
  output logic [2*LANES-1:0]      cc0_out,
  output logic [2*LANES-1:0]      cc1_out
);
  localparam int SEL_W = $clog2(LANES);
  localparam int MAN_W = DATA_W - 1 - EXP_W;
  localparam logic [DATA_W-1:0] FP_ONE = {2'b00, {(EXP_W-1){1'b1}}, {MAN_W{1'b0}}};

  logic                    go;
  logic [2*LANES-1:0]      cc_q [NUM_CC];
  logic [2*LANES-1:0]      test_vec;
  logic [2*LANES-1:0]      new_codes;
  logic [LANES-1:0]        lane_pass;
  logic [LANES-1:0]        lane_we;
  logic [LANES*DATA_W-1:0] wr_vals;
  logic [LANES*DATA_W-1:0] merged;

  assign go       = issue && !run_start;
  assign test_vec = cc_q[test_cc_sel];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    ccm_lane_prep #(.DATA_W(DATA_W), .EXP_W(EXP_W)) u_prep (
      .val_in   (res_vec[DATA_W*i +: DATA_W]),
      .sat_en   (sat_en),
      .int_mode (int_mode),
      .val_out  (wr_vals[DATA_W*i +: DATA_W]),
      .code_out (new_codes[2*i +: 2])
    );

    ccm_lane_test #(.LANES(LANES), .SEL_W(SEL_W)) u_test (
      .cc_vec (test_vec),
      .pick   (test_swz[SEL_W*i +: SEL_W]),
      .rule   (test_rule),
      .pass   (lane_pass[i])
    );

    assign lane_we[i] = wr_mask[i] && lane_pass[i];
    assign merged[DATA_W*i +: DATA_W] = lane_we[i] ? wr_vals[DATA_W*i +: DATA_W]
                                                   : dst_vec[DATA_W*i +: DATA_W];

    AST_MASK_KEEP: assert property (@(posedge clk) disable iff (rst)
      go && !wr_mask[i] |=> dst_out[DATA_W*i +: DATA_W] == $past(dst_vec[DATA_W*i +: DATA_W])); // R6

    AST_SAT_RANGE: assert property (@(posedge clk) disable iff (rst)
      go && sat_en && !int_mode && lane_we[i] |=>
        !dst_out[DATA_W*i + DATA_W-1] && (dst_out[DATA_W*i +: DATA_W] <= FP_ONE)); // R8
  end

  for (genvar k = 0; k < NUM_CC; k++) begin : g_cc
    logic upd_k;
    assign upd_k = go && cc_wr_en && (cc_wr_sel == CCSEL_W'(k));

    ccm_cc_reg #(.LANES(LANES)) u_cc (
      .clk       (clk),
      .rst       (rst),
      .clear     (run_start),
      .upd       (upd_k),
      .lane_we   (lane_we),
      .new_codes (new_codes),
      .cc_q      (cc_q[k])
    );

    AST_OTHER_CC_STABLE: assert property (@(posedge clk) disable iff (rst)
      go && (!cc_wr_en || cc_wr_sel != CCSEL_W'(k)) |=> $stable(cc_q[k])); // R7
  end

  assign cc0_out = cc_q[0];
  assign cc1_out = cc_q[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      dst_out   <= '0;
      dst_valid <= 1'b0;
    end else begin
      dst_valid <= go;
      if (go) dst_out <= merged;
    end
  end

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    run_start |=> (cc0_out == {LANES{CC_EQ}}) && (cc1_out == {LANES{CC_EQ}}) && !dst_valid); // R1

  AST_FL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    go && test_rule == RULE_FL |=> dst_out == $past(dst_vec)); // R4

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    go |=> dst_valid); // R6

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !go |=> !dst_valid && $stable(dst_out)); // R6
endmodule

// File: tb/ccm_merge_unit_bench.sv
`timescale 1ns/1ps
module ccm_merge_unit_bench;
  localparam logic [31:0] Z    = 32'h0000_0000;
  localparam logic [31:0] NZ   = 32'h8000_0000;
  localparam logic [31:0] ONE  = 32'h3F80_0000;
  localparam logic [31:0] HALF = 32'h3F00_0000;
  localparam logic [31:0] TWO  = 32'h4000_0000;
  localparam logic [31:0] M2   = 32'hC000_0000;
  localparam logic [31:0] QNAN = 32'h7FC0_0000;
  localparam logic [31:0] PINF = 32'h7F80_0000;
  localparam logic [7:0]  SW_ID  = 8'hE4;
  localparam logic [7:0]  SW_ZYX = 8'hC6;

  typedef struct packed {
    logic [127:0] res;
    logic [127:0] old;
    logic [3:0]   wm;
    logic         ts;
    logic [7:0]   swz;
    logic [2:0]   rule;
    logic         sat;
    logic         isint;
    logic         upd;
    logic         usel;
    logic [127:0] exp;
    logic [7:0]   e0;
    logic [7:0]   e1;
    logic [7:0]   rq;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    // R3: first code load into register 0
    '{ {QNAN,TWO,Z,M2}, {HALF,HALF,HALF,HALF}, 4'hF, 1'b0, SW_ID, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, {QNAN,TWO,Z,M2}, 8'hC6, 8'h55, 8'd3 },
    // R6 R7: partial mask, untouched lane keeps value and code
    '{ {M2,QNAN,TWO,Z}, {QNAN,TWO,Z,M2}, 4'h7, 1'b0, SW_ID, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, {QNAN,QNAN,TWO,Z}, 8'hF1, 8'h55, 8'd6 },
    // R4: not-equal passes unordered lanes
    '{ {M2,QNAN,Z,TWO}, {QNAN,QNAN,TWO,Z}, 4'hF, 1'b0, SW_ID, 3'd3, 1'b0, 1'b0, 1'b1, 1'b0, {M2,QNAN,Z,Z}, 8'hB5, 8'h55, 8'd4 },
    // R7: update register 1 only
    '{ {ONE,Z,M2,TWO}, {Z,Z,Z,Z}, 4'hF, 1'b0, SW_ID, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, {ONE,Z,M2,TWO}, 8'hB5, 8'h18, 8'd7 },
    // R5: swizzle zyxw on register 1 with not-equal
    '{ {HALF,HALF,HALF,HALF}, {TWO,TWO,TWO,TWO}, 4'hF, 1'b1, SW_ZYX, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0, {HALF,HALF,HALF,TWO}, 8'hB5, 8'h18, 8'd5 },
    // R8: clamp -2, 2, NaN, -0
    '{ {NZ,QNAN,TWO,M2}, {Z,Z,Z,Z}, 4'hF, 1'b0, SW_ID, 3'd0, 1'b1, 1'b0, 1'b1, 1'b0, {Z,Z,ONE,Z}, 8'h51, 8'h18, 8'd8 },
    // R4: greater-or-equal
    '{ {HALF,HALF,HALF,HALF}, {Z,Z,Z,Z}, 4'hF, 1'b1, SW_ID, 3'd5, 1'b0, 1'b0, 1'b0, 1'b0, {HALF,HALF,Z,HALF}, 8'h51, 8'h18, 8'd4 },
    // R4: less-or-equal
    '{ {HALF,HALF,HALF,HALF}, {Z,Z,Z,Z}, 4'hF, 1'b1, SW_ID, 3'd6, 1'b0, 1'b0, 1'b0, 1'b0, {Z,HALF,HALF,Z}, 8'h51, 8'h18, 8'd4 },
    // R4: less
    '{ {HALF,HALF,HALF,HALF}, {Z,Z,Z,Z}, 4'hF, 1'b1, SW_ID, 3'd4, 1'b0, 1'b0, 1'b0, 1'b0, {Z,Z,HALF,Z}, 8'h51, 8'h18, 8'd4 },
    // R4: greater
    '{ {HALF,HALF,HALF,HALF}, {Z,Z,Z,Z}, 4'hF, 1'b1, SW_ID, 3'd7, 1'b0, 1'b0, 1'b0, 1'b0, {HALF,Z,Z,HALF}, 8'h51, 8'h18, 8'd4 },
    // R4: equal
    '{ {HALF,HALF,HALF,HALF}, {Z,Z,Z,Z}, 4'hF, 1'b1, SW_ID, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, {Z,HALF,Z,Z}, 8'h51, 8'h18, 8'd4 },
    // R4: never, with update requested: nothing changes
    '{ {HALF,HALF,HALF,HALF}, {TWO,TWO,TWO,TWO}, 4'hF, 1'b1, SW_ID, 3'd1, 1'b0, 1'b0, 1'b1, 1'b1, {TWO,TWO,TWO,TWO}, 8'h51, 8'h18, 8'd4 },
    // R3: all NaN gives unordered
    '{ {QNAN,QNAN,QNAN,QNAN}, {Z,Z,Z,Z}, 4'hF, 1'b0, SW_ID, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, {QNAN,QNAN,QNAN,QNAN}, 8'hFF, 8'h18, 8'd3 },
    // R4: unordered fails greater-or-equal
    '{ {HALF,HALF,HALF,HALF}, {ONE,ONE,ONE,ONE}, 4'hF, 1'b0, SW_ID, 3'd5, 1'b0, 1'b0, 1'b0, 1'b0, {ONE,ONE,ONE,ONE}, 8'hFF, 8'h18, 8'd4 },
    // R4: unordered passes not-equal
    '{ {HALF,HALF,HALF,HALF}, {ONE,ONE,ONE,ONE}, 4'hF, 1'b0, SW_ID, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0, {HALF,HALF,HALF,HALF}, 8'hFF, 8'h18, 8'd4 },
    // R9: integer mode ignores clamp, signed codes
    '{ {32'h8000_0000,32'h0000_0005,Z,32'hFFFF_FFFE}, {Z,Z,Z,Z}, 4'hF, 1'b0, SW_ID, 3'd0, 1'b1, 1'b1, 1'b1, 1'b1, {32'h8000_0000,32'h0000_0005,Z,32'hFFFF_FFFE}, 8'hFF, 8'h86, 8'd9 },
    // R3: +inf greater, -0 equal
    '{ {Z,ONE,NZ,PINF}, {Z,Z,Z,Z}, 4'hF, 1'b0, SW_ID, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, {Z,ONE,NZ,PINF}, 8'h44, 8'h86, 8'd3 },
    // R10: test sees codes before own update
    '{ {TWO,TWO,M2,M2}, {Z,Z,Z,Z}, 4'hF, 1'b0, SW_ID, 3'd7, 1'b0, 1'b0, 1'b1, 1'b0, {Z,TWO,Z,M2}, 8'h46, 8'h86, 8'd10 }
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         run_start = 1'b0;
  logic         issue = 1'b0;
  logic [127:0] res_vec = '0;
  logic [127:0] dst_vec = '0;
  logic [3:0]   wr_mask = '0;
  logic         test_cc_sel = 1'b0;
  logic [7:0]   test_swz = SW_ID;
  logic [2:0]   test_rule = '0;
  logic         sat_en = 1'b0;
  logic         int_mode = 1'b0;
  logic         cc_wr_en = 1'b0;
  logic         cc_wr_sel = 1'b0;
  logic [127:0] dst_out;
  logic         dst_valid;
  logic [7:0]   cc0_out;
  logic [7:0]   cc1_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  ccm_merge_unit u_ccm_merge_unit (
    .clk(clk), .rst(rst), .run_start(run_start), .issue(issue),
    .res_vec(res_vec), .dst_vec(dst_vec), .wr_mask(wr_mask),
    .test_cc_sel(test_cc_sel), .test_swz(test_swz), .test_rule(test_rule),
    .sat_en(sat_en), .int_mode(int_mode), .cc_wr_en(cc_wr_en), .cc_wr_sel(cc_wr_sel),
    .dst_out(dst_out), .dst_valid(dst_valid), .cc0_out(cc0_out), .cc1_out(cc1_out)
  );

  task automatic chk(input bit ok, input string what, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    @(negedge clk);
    issue = 1'b1; res_vec = v.res; dst_vec = v.old; wr_mask = v.wm;
    test_cc_sel = v.ts; test_swz = v.swz; test_rule = v.rule;
    sat_en = v.sat; int_mode = v.isint; cc_wr_en = v.upd; cc_wr_sel = v.usel;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    // R1: reset state
    chk(cc0_out == 8'h55, "R1 reset cc0", 128'(cc0_out), 128'h55);
    chk(cc1_out == 8'h55, "R1 reset cc1", 128'(cc1_out), 128'h55);
    chk(dst_valid == 1'b0, "R1 reset valid", 128'(dst_valid), 128'h0);

    for (int n = 0; n < NV; n++) begin
      drive(VECS[n]);
      chk(dst_out == VECS[n].exp, $sformatf("R%0d vec %0d dst_out", VECS[n].rq, n), dst_out, VECS[n].exp);
      chk(cc0_out == VECS[n].e0, $sformatf("R2 R%0d vec %0d cc0", VECS[n].rq, n), 128'(cc0_out), 128'(VECS[n].e0));
      chk(cc1_out == VECS[n].e1, $sformatf("R2 R%0d vec %0d cc1", VECS[n].rq, n), 128'(cc1_out), 128'(VECS[n].e1));
      chk(dst_valid == 1'b1, $sformatf("R6 vec %0d valid", n), 128'(dst_valid), 128'h1);
    end

    // R6: idle cycle holds output, no valid
    @(negedge clk);
    issue = 1'b0;
    @(posedge clk);
    #1;
    chk(dst_valid == 1'b0, "R6 idle valid", 128'(dst_valid), 128'h0);
    chk(dst_out == {Z,TWO,Z,M2}, "R6 idle hold", dst_out, {Z,TWO,Z,M2});

    // R1: run_start alone clears both registers
    @(negedge clk);
    run_start = 1'b1;
    @(posedge clk);
    #1;
    chk(cc0_out == 8'h55, "R1 start cc0", 128'(cc0_out), 128'h55);
    chk(cc1_out == 8'h55, "R1 start cc1", 128'(cc1_out), 128'h55);
    @(negedge clk);
    run_start = 1'b0;

    // load register 1 with less codes, then start with a same-cycle issue
    drive('{ {M2,M2,M2,M2}, {Z,Z,Z,Z}, 4'hF, 1'b0, SW_ID, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, {M2,M2,M2,M2}, 8'h55, 8'hAA, 8'd7 });
    chk(cc1_out == 8'hAA, "R7 reload cc1", 128'(cc1_out), 128'hAA);
    @(negedge clk);
    run_start = 1'b1; issue = 1'b1; res_vec = {ONE,ONE,ONE,ONE};
    @(posedge clk);
    #1;
    // R1: start wins over issue
    chk(dst_valid == 1'b0, "R1 start drops issue valid", 128'(dst_valid), 128'h0);
    chk(dst_out == {M2,M2,M2,M2}, "R1 start drops issue dst", dst_out, {M2,M2,M2,M2});
    chk(cc1_out == 8'h55, "R1 start over issue cc1", 128'(cc1_out), 128'h55);
    @(negedge clk);
    run_start = 1'b0; issue = 1'b0;
    @(posedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule